// File: doc/BRIEF.md
# Centralized Hazard Scoreboard Controller

This block is the dispatch and hazard controller for a small machine that issues in order and completes out of order. It has eight architectural registers and five execution units. Unit 0 handles integer and load work, units 1 and 2 are multipliers, unit 3 is an adder and unit 4 is a divider. A decoder presents one instruction at a time through a valid/ready port. Each instruction carries a class code, a destination and two source register indices. The controller picks the unit and records the instruction in that unit's status entry. It then grants, in turn, the operand read, the execution start and the register-file write.

There is no forwarding path. A consumer reads its sources only after every earlier producer of those registers has written the register file. Write-after-write conflicts are prevented at issue. Write-after-read conflicts are resolved by holding a finished result until every earlier reader has taken its old operand. Execution is modelled inside the block by one latency counter per unit. The counter starts on the operand-read grant. The register file datapath and the arithmetic sit outside the block.

Top module: `hazard_scoreboard`

## Requirements
- R1: An instruction is accepted on a clock edge where `iss_valid` and `iss_ready` are both high, strictly in the order presented. `iss_fu` names the chosen unit. Class code 0 (integer/load) goes to unit 0. Class 1 (multiply) goes to unit 1 if it is free, otherwise unit 2. Class 2 (add) goes to unit 3 and class 3 (divide) to unit 4.
- R2: `iss_ready` is low while every unit able to run the presented class is occupied (structural hazard).
- R3: `iss_ready` is low while the presented destination register has a pending writer, that is, an accepted instruction that has not yet written back.
- R4: `rd_gnt[u]` pulses for exactly one cycle per instruction. It comes no earlier than the cycle after the last pending producer of either source has written back. With no pending producer, it comes in the cycle right after acceptance.
- R5: After the operand read, a unit finishes after its latency parameter. Its earliest write-back comes latency+1 cycles after the `rd_gnt` cycle.
- R6: A finished unit does not write back while any other unit still waits to read that register as a source whose ready flag is set.
- R7: A write-back is a one-cycle `wb_en` pulse with `wb_idx` equal to the unit's destination and `wb_fu` naming the unit. It frees both the unit and the register. A new instruction with the same destination is accepted as early as the following cycle.
- R8: At most one write-back takes place per cycle. Among eligible units, the lowest unit index wins.
- R9: After reset, all units are free, no register has a pending writer, `wb_en` and `rd_gnt` are low, and `iss_ready` is high.
- R10: When operands are read at `rd_gnt` and results are written at `wb_en`, the resulting register file matches strictly sequential execution of the same program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Decoded instruction present |
| iss_cls | input | 2 | Class code: 0 int/load, 1 mul, 2 add, 3 div |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_src1 | input | $clog2(NREG) | First source register |
| iss_src2 | input | $clog2(NREG) | Second source register |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| iss_fu | output | 3 | Unit that takes the presented instruction |
| rd_gnt | output | 5 | Per-unit operand-read grant (execution starts) |
| wb_en | output | 1 | Register-file write this cycle |
| wb_idx | output | $clog2(NREG) | Register written |
| wb_fu | output | 3 | Unit writing back |

## Verification
The bench builds the block with eight registers and latencies of 1, 3, 2 and 6 cycles for the integer, multiply, add and divide units. The short divider makes a reader wait on a long producer within a few cycles. Meanwhile both multipliers finish early and become blocked by write-after-read conflicts. Both are then released in the same cycle, which exercises the fixed write priority against the integer and add units. The small latencies also let several hundred random instructions run to a register-file comparison against sequential execution within the cycle budget.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam int NFU = 5;   // int/load, mul, mul, add, div
  localparam int FW  = 3;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_ADD = 2'd2,
    CLS_DIV = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    ST_FREE,
    ST_OPND,
    ST_EXEC,
    ST_DONE
  } fu_st_e;

  typedef struct packed {
    logic          ok;
    logic [FW-1:0] idx;
  } pick_t;

  // R1/R2: unit selection per class, lowest free multiplier first
  function automatic pick_t pick_unit(input logic [NFU-1:0] busy, input cls_e c);
    pick_t p;
    p.ok  = 1'b0;
    p.idx = '0;
    case (c)
      CLS_INT: begin p.ok = !busy[0]; p.idx = 3'd0; end
      CLS_MUL: begin
        if (!busy[1])      begin p.ok = 1'b1; p.idx = 3'd1; end
        else if (!busy[2]) begin p.ok = 1'b1; p.idx = 3'd2; end
        else               p.idx = 3'd1;
      end
      CLS_ADD: begin p.ok = !busy[3]; p.idx = 3'd3; end
      default: begin p.ok = !busy[4]; p.idx = 3'd4; end
    endcase
    return p;
  endfunction

  // R6: a waiting reader holds an old value of register dst
  function automatic logic reader_holds(input int unsigned fj, input int unsigned fk,
                                        input logic rj, input logic rk,
                                        input int unsigned dst);
    return (rj && fj == dst) || (rk && fk == dst);
  endfunction
endpackage

// File: rtl/hsb_lat_timer.sv
module hsb_lat_timer #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= CW'(LAT);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));
endmodule

// File: rtl/hsb_wb_arb.sv
module hsb_wb_arb #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  // R8: lowest index wins
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
  import hsb_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 4,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 10,
  localparam int RW     = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [1:0]     iss_cls,
  input  logic [RW-1:0]  iss_dst,
  input  logic [RW-1:0]  iss_src1,
  input  logic [RW-1:0]  iss_src2,
  output logic           iss_ready,
  output logic [FW-1:0]  iss_fu,
  output logic [NFU-1:0] rd_gnt,
  output logic           wb_en,
  output logic [RW-1:0]  wb_idx,
  output logic [FW-1:0]  wb_fu
);
  // per-unit status
  fu_st_e          st [NFU];
  logic [RW-1:0]   fi [NFU];
  logic [RW-1:0]   fj [NFU];
  logic [RW-1:0]   fk [NFU];
  logic [FW-1:0]   qj [NFU];
  logic [FW-1:0]   qk [NFU];
  logic [NFU-1:0]  rj, rk;
  // register result table
  logic [NREG-1:0] regv;
  logic [FW-1:0]   regq [NREG];

  // named internal events
  logic [NFU-1:0]  busy, done, war_blk, wb_req, wb_gnt;
  pick_t           pk;
  logic            dst_pend, iss_fire, s1_wait, s2_wait;

  assign pk        = pick_unit(busy, cls_e'(iss_cls));
  assign dst_pend  = regv[iss_dst];                 // R3
  assign iss_ready = pk.ok && !dst_pend;            // R2, R3
  assign iss_fu    = pk.idx;
  assign iss_fire  = iss_valid && iss_ready;        // R1
  // a producer writing back this very cycle counts as already written
  assign s1_wait   = regv[iss_src1] && !(wb_en && wb_idx == iss_src1);
  assign s2_wait   = regv[iss_src2] && !(wb_en && wb_idx == iss_src2);

  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      busy[u]    = (st[u] != ST_FREE);
      rd_gnt[u]  = (st[u] == ST_OPND) && rj[u] && rk[u];       // R4
      war_blk[u] = 1'b0;
      for (int f = 0; f < NFU; f++) begin
        if (f != u && st[f] == ST_OPND &&
            reader_holds(fj[f], fk[f], rj[f], rk[f], fi[u]))
          war_blk[u] = 1'b1;                                   // R6
      end
      wb_req[u]  = (st[u] == ST_DONE) && !war_blk[u];
    end
  end

  hsb_wb_arb #(.N(NFU), .IW(FW)) u_arb (
    .req (wb_req),
    .gnt (wb_gnt),
    .any (wb_en),
    .idx (wb_fu)
  );
  assign wb_idx = fi[wb_fu];                                   // R7

  // R5: one latency counter per unit
  for (genvar g = 0; g < NFU; g++) begin : g_timer
    localparam int LAT_G = (g == 0) ? LAT_INT :
                           (g <= 2) ? LAT_MUL :
                           (g == 3) ? LAT_ADD : LAT_DIV;
    hsb_lat_timer #(.LAT(LAT_G)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rd_gnt[g]),
      .done  (done[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NFU; u++) begin
        st[u] <= ST_FREE;
        fi[u] <= '0; fj[u] <= '0; fk[u] <= '0;
        qj[u] <= '0; qk[u] <= '0;
      end
      rj <= '0;
      rk <= '0;
    end else begin
      for (int u = 0; u < NFU; u++) begin
        case (st[u])
          ST_FREE: if (iss_fire && pk.idx == FW'(u)) begin
            st[u] <= ST_OPND;
            fi[u] <= iss_dst;
            fj[u] <= iss_src1;
            fk[u] <= iss_src2;
            rj[u] <= !s1_wait;
            rk[u] <= !s2_wait;
            qj[u] <= s1_wait ? regq[iss_src1] : '0;
            qk[u] <= s2_wait ? regq[iss_src2] : '0;
          end
          ST_OPND: if (rd_gnt[u]) begin
            // operands taken: old sources no longer block any writer
            st[u] <= ST_EXEC;
            rj[u] <= 1'b0; rk[u] <= 1'b0;
            qj[u] <= '0;   qk[u] <= '0;
          end else begin
            if (wb_en && !rj[u] && qj[u] == wb_fu) rj[u] <= 1'b1;
            if (wb_en && !rk[u] && qk[u] == wb_fu) rk[u] <= 1'b1;
          end
          ST_EXEC: if (done[u])   st[u] <= ST_DONE;
          default: if (wb_gnt[u]) st[u] <= ST_FREE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regv <= '0;
      for (int r = 0; r < NREG; r++) regq[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wb_en && wb_idx == RW'(r)) regv[r] <= 1'b0;
        if (iss_fire && iss_dst == RW'(r)) begin
          regv[r] <= 1'b1;
          regq[r] <= pk.idx;
        end
      end
    end
  end
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int NFU  = 5,
  parameter int NREG = 8,
  parameter int RW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic            dst_pend,
  input logic [NFU-1:0]  rd_gnt,
  input logic [NFU-1:0]  wb_req,
  input logic [NFU-1:0]  wb_gnt,
  input logic [NFU-1:0]  war_blk,
  input logic [NREG-1:0] regv,
  input logic            wb_en,
  input logic [RW-1:0]   wb_idx
);
  p_waw_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && dst_pend) |-> !iss_ready)
    else $error("R3 issue accepted over pending writer");

  p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_gnt))
    else $error("R8 more than one write-back");

  p_wb_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !regv[$past(wb_idx)])
    else $error("R7 register still pending after write-back");

  for (genvar u = 0; u < NFU; u++) begin : g_unit
    localparam logic [NFU-1:0] LOWER = NFU'((1 << u) - 1);

    p_no_war_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_gnt[u] |-> !war_blk[u])
      else $error("R6 write-back over waiting reader");

    p_low_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_gnt[u] |-> ((wb_req & LOWER) == '0))
      else $error("R8 lower unit was eligible");

    p_read_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt[u] |=> !rd_gnt[u])
      else $error("R4 operand read repeated");
  end
endmodule

bind hazard_scoreboard hsb_checker #(
  .NFU  (hsb_pkg::NFU),
  .NREG (NREG),
  .RW   (RW)
) u_hsb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .dst_pend  (dst_pend),
  .rd_gnt    (rd_gnt),
  .wb_req    (wb_req),
  .wb_gnt    (wb_gnt),
  .war_blk   (war_blk),
  .regv      (regv),
  .wb_en     (wb_en),
  .wb_idx    (wb_idx)
);

// File: tb/test_hazard_scoreboard.sv
`timescale 1ns/1ps
module test_hazard_scoreboard;
  localparam int NREG = 8;
  localparam int LI = 1, LM = 3, LA = 2, LD = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid;
  logic [1:0] iss_cls;
  logic [2:0] iss_dst, iss_src1, iss_src2;
  logic       iss_ready;
  logic [2:0] iss_fu;
  logic [4:0] rd_gnt;
  logic       wb_en;
  logic [2:0] wb_idx;
  logic [2:0] wb_fu;

  always #2 clk = ~clk;   // 250 MHz

  hazard_scoreboard #(.NREG(NREG), .LAT_INT(LI), .LAT_MUL(LM),
                      .LAT_ADD(LA), .LAT_DIV(LD)) i_hazard_scoreboard (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .iss_fu(iss_fu), .rd_gnt(rd_gnt),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_fu(wb_fu));

  int checks = 0, errors = 0, cyc = 0, n_iss = 0, n_wb = 0;
  logic [15:0] rf [NREG];
  logic [15:0] ref_rf [NREG];
  logic [15:0] exp_q [$];
  int          slot_seq [5];
  logic [1:0]  slot_cls [5];
  logic [2:0]  slot_d [5], slot_a [5], slot_b [5];
  logic [15:0] slot_res [5];
  int          rd_at [5];
  int          wbfu_q [$];
  int          wbcy_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] calc(input logic [1:0] c, input logic [15:0] a, input logic [15:0] b);
    case (c)
      2'd0:    return a - b;
      2'd1:    return a * b;
      2'd2:    return a + b;
      default: return a / (b | 16'd1);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find_wb(input int u);
    foreach (wbfu_q[i]) if (wbfu_q[i] == u) return wbcy_q[i];
    return -1;
  endfunction

  // monitor: operands read at rd_gnt, results compared and written at wb_en
  always @(negedge clk) begin
    if (rst_n) begin
      for (int u = 0; u < 5; u++) begin
        if (rd_gnt[u]) begin
          slot_res[u] = calc(slot_cls[u], rf[slot_a[u]], rf[slot_b[u]]);
          rd_at[u]    = cyc;
        end
      end
      if (wb_en) begin
        check(wb_idx == slot_d[wb_fu], "R7", "write-back register", int'(wb_idx), int'(slot_d[wb_fu]));
        check(slot_res[wb_fu] == exp_q[slot_seq[wb_fu]], "R10", "written value",
              int'(slot_res[wb_fu]), int'(exp_q[slot_seq[wb_fu]]));
        rf[wb_idx] = slot_res[wb_fu];
        wbfu_q.push_back(int'(wb_fu));
        wbcy_q.push_back(cyc);
        n_wb++;
      end
    end
  end

  // driver: waits for acceptance, records the slot and the sequential result
  task automatic issue(input logic [1:0] c, input logic [2:0] d, input logic [2:0] a,
                       input logic [2:0] b, output int rc, output int fu);
    logic [15:0] v;
    @(negedge clk);
    iss_valid = 1'b1; iss_cls = c; iss_dst = d; iss_src1 = a; iss_src2 = b;
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    rc = cyc;
    fu = int'(iss_fu);
    slot_seq[fu] = n_iss; slot_cls[fu] = c; slot_d[fu] = d; slot_a[fu] = a; slot_b[fu] = b;
    v = calc(c, ref_rf[a], ref_rf[b]);
    exp_q.push_back(v);
    ref_rf[d] = v;
    n_iss++;
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic probe(input logic [1:0] c, input logic [2:0] d, output bit rdy);
    @(negedge clk);
    iss_valid = 1'b1; iss_cls = c; iss_dst = d; iss_src1 = 3'd0; iss_src2 = 3'd0;
    #1 rdy = iss_ready;
    iss_valid = 1'b0;
  endtask

  task automatic drain();
    while (n_wb < n_iss) @(negedge clk);
    repeat (2) @(negedge clk);
    wbfu_q.delete();
    wbcy_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d write-backs", n_wb, n_iss);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rc, fu, rc2, w;
    bit rdy;
    for (int i = 0; i < NREG; i++) begin rf[i] = 16'(i * 7 + 3); ref_rf[i] = rf[i]; end
    rst_n = 1'b0; iss_valid = 1'b0; iss_cls = '0; iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(iss_ready == 1'b1, "R9", "iss_ready in reset", int'(iss_ready), 1);
    check(wb_en == 1'b0, "R9", "wb_en in reset", int'(wb_en), 0);
    check(rd_gnt == '0, "R9", "rd_gnt in reset", int'(rd_gnt), 0);
    rst_n = 1'b1;

    // R1, R4, R5, R7: lone integer op, then a write-after-write follower
    issue(2'd0, 3'd1, 3'd2, 3'd3, rc, fu);
    check(fu == 0, "R1", "integer unit", fu, 0);
    issue(2'd0, 3'd1, 3'd1, 3'd2, rc2, fu);
    check(rc2 == rc + LI + 3, "R7", "same-destination accept cycle", rc2, rc + LI + 3);
    drain();

    // R2, R3, R4: divider busy, pending destination, read-after-write wait
    issue(2'd3, 3'd4, 3'd5, 3'd6, rc, fu);
    check(fu == 4, "R1", "divide unit", fu, 4);
    probe(2'd3, 3'd0, rdy);
    check(rdy == 1'b0, "R2", "second divide stalls", int'(rdy), 0);
    probe(2'd0, 3'd4, rdy);
    check(rdy == 1'b0, "R3", "pending destination stalls", int'(rdy), 0);
    probe(2'd0, 3'd0, rdy);
    check(rdy == 1'b1, "R1", "free unit and register accept", int'(rdy), 1);
    issue(2'd2, 3'd2, 3'd1, 3'd4, rc, fu);
    drain();
    // queues cleared by drain; recompute from recorded cycles
    check(rd_at[3] > rd_at[4] + LD, "R4", "add read after divide write", rd_at[3], rd_at[4] + LD + 1);
    check(rd_at[3] == rd_at[4] + LD + 2, "R4", "add read cycle", rd_at[3], rd_at[4] + LD + 2);

    // R1, R2: multiplier allocation
    issue(2'd1, 3'd1, 3'd2, 3'd3, rc, fu);
    check(fu == 1, "R1", "first multiplier", fu, 1);
    issue(2'd1, 3'd5, 3'd3, 3'd3, rc, fu);
    check(fu == 2, "R1", "second multiplier", fu, 2);
    probe(2'd1, 3'd6, rdy);
    check(rdy == 1'b0, "R2", "third multiply stalls", int'(rdy), 0);
    drain();

    // R6, R8: two readers wait on the divider, both multipliers blocked by WAR
    issue(2'd3, 3'd7, 3'd1, 3'd2, rc, fu);
    issue(2'd2, 3'd5, 3'd1, 3'd7, rc, fu);
    issue(2'd0, 3'd6, 3'd3, 3'd7, rc, fu);
    issue(2'd1, 3'd1, 3'd2, 3'd2, rc, fu);
    issue(2'd1, 3'd3, 3'd2, 3'd2, rc, fu);
    while (n_wb < n_iss) @(negedge clk);
    w = find_wb(4);
    check(wbfu_q.size() == 5, "R8", "write-back count", wbfu_q.size(), 5);
    if (wbfu_q.size() == 5) begin
      check(wbfu_q[1] == 1 && wbcy_q[1] == w + 2, "R8", "mul1 first after release", wbcy_q[1] - w, 2);
      check(wbfu_q[2] == 0 && wbcy_q[2] == w + 3, "R8", "int beats mul2", wbfu_q[2], 0);
      check(wbfu_q[3] == 2 && wbcy_q[3] == w + 4, "R8", "mul2 beats add", wbfu_q[3], 2);
      check(wbfu_q[4] == 3 && wbcy_q[4] == w + 5, "R5", "add write cycle", wbcy_q[4] - w, 5);
    end
    check(find_wb(1) > rd_at[3], "R6", "mul1 waits for add read", find_wb(1), rd_at[3] + 1);
    check(find_wb(2) > rd_at[0], "R6", "mul2 waits for int read", find_wb(2), rd_at[0] + 1);
    drain();

    // R10: random program against sequential execution
    for (int k = 0; k < 300; k++)
      issue(2'($urandom % 4), 3'($urandom % 8), 3'($urandom % 8), 3'($urandom % 8), rc, fu);
    drain();
    for (int i = 0; i < NREG; i++)
      check(rf[i] == ref_rf[i], "R10", $sformatf("final r%0d", i), int'(rf[i]), int'(ref_rf[i]));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule